// File: doc/BRIEF.md
# XY-Routed Router Input Channel

This block is the input side of one port of a five-port mesh router. A neighbouring router offers a packet over a request/acknowledge handshake. The channel takes one flit per cycle into a 16-entry, 8-bit buffer for as long as both lines stay high. When the neighbour drops its request, the channel looks at the first flit, which is the header. It compares the destination coordinates in the header with the router's own coordinates. The X dimension is resolved before the Y dimension, and the result picks one output direction.

The channel then raises a request to exactly one output channel and holds it until a grant comes back. After the grant, it drains the whole packet, header included, one flit per cycle toward the crossbar. The buffer's empty flag alone marks the end of the packet. Once that flag is seen, the channel returns to idle and may accept the next packet. Output arbitration and the crossbar itself sit outside this block.

Top module: `xy_input_channel`

## Requirements
- R1: While reset is held and right after it, in_ack_o is low, out_req_o is all zero, out_valid_o is low and empty_o is high.
- R2: Acknowledge is raised only in the cycle after a request has been seen while the channel is idle. While the channel is routing, requesting or forwarding, acknowledge stays low even if the neighbour asserts request, and the flits offered then are not stored.
- R3: A flit is stored on every rising clock edge where in_req_i and in_ack_o are both high, and the buffer keeps the flits in arrival order, up to 16 of them.
- R4: When the buffer holds 16 flits, acknowledge drops and stays low. Flits offered while it is full are not stored.
- R5: In the cycle where the neighbour has dropped request, acknowledge is still high (unless the buffer is full). It is low from the next cycle on.
- R6: The header's bits 7:4 hold the destination X and bits 3:0 hold the destination Y. If destination X is greater than local X, the request is East; if it is smaller, the request is West. Y is then not looked at.
- R7: If the X values are equal, Y decides: greater gives North, smaller gives South, equal gives Local.
- R8: out_req_o is one-hot, with bit 0 North, bit 1 East, bit 2 South, bit 3 West and bit 4 Local. It appears two cycles after request falls and is held unchanged until out_gnt_i is seen. It is zero from the cycle after the grant.
- R9: From the cycle after the grant, out_valid_o is high with one stored flit on out_data_o per cycle, in order and header first, until the buffer is empty.
- R10: empty_o rises once the last flit has left. The channel then returns to idle and accepts the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| local_x_i | input | 4 | X coordinate of this router |
| local_y_i | input | 4 | Y coordinate of this router |
| in_req_i | input | 1 | Request from the neighbour |
| in_data_i | input | 8 | Flit from the neighbour |
| in_ack_o | output | 1 | Acknowledge to the neighbour |
| out_req_o | output | 5 | One-hot output channel request (N,E,S,W,L on bits 0..4) |
| out_gnt_i | input | 1 | Grant from the requested output channel |
| out_data_o | output | 8 | Flit toward the crossbar |
| out_valid_o | output | 1 | out_data_o carries a flit this cycle |
| empty_o | output | 1 | Buffer empty; marks the end of a drained packet |

## Verification
Two things can coincide in one cycle. The first is the write that fills the buffer, which happens while the neighbour keeps request high: acknowledge must drop in the cycle after the 16th write, and the bench holds request and changes the data for several more cycles. The check then confirms that exactly the first 16 flits come out. The second is a neighbour that raises request while the channel is busy requesting its output: the bench checks that acknowledge stays low in those cycles and that the drained stream holds no stray flit.

// File: rtl/xy_chan_pkg.sv
package xy_chan_pkg;
  localparam int NUM_DIRS = 5;
  localparam int DIR_N = 0;
  localparam int DIR_E = 1;
  localparam int DIR_S = 2;
  localparam int DIR_W = 3;
  localparam int DIR_L = 4;

  typedef logic [NUM_DIRS-1:0] dir_vec_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ROUTE,
    ST_REQ,
    ST_FWD
  } ch_state_e;
endpackage

// File: rtl/xy_chan_fifo.sv
module xy_chan_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o
);
  // DEPTH must be a power of two; the pointers carry one wrap bit.
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr, rd_ptr;
  logic             wr_ok, rd_ok;

  assign full_o  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign empty_o = (wr_ptr == rd_ptr);
  assign wr_ok   = wr_en_i && !full_o;
  assign rd_ok   = rd_en_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wr_ptr[AW-1:0]] <= wr_data_i;
  end

  // show-ahead: head entry is always visible
  assign rd_data_o = mem[rd_ptr[AW-1:0]];
endmodule

// File: rtl/xy_chan_route.sv
module xy_chan_route
  import xy_chan_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic [2*COORD_W-1:0] header_i,
  input  logic [COORD_W-1:0]   local_x_i,
  input  logic [COORD_W-1:0]   local_y_i,
  output dir_vec_t             dir_o
);
  logic [COORD_W-1:0] dst_x, dst_y;

  assign dst_x = header_i[2*COORD_W-1:COORD_W];
  assign dst_y = header_i[COORD_W-1:0];

  always_comb begin
    dir_o = '0;
    if (dst_x > local_x_i)      dir_o[DIR_E] = 1'b1;
    else if (dst_x < local_x_i) dir_o[DIR_W] = 1'b1;
    else if (dst_y > local_y_i) dir_o[DIR_N] = 1'b1;
    else if (dst_y < local_y_i) dir_o[DIR_S] = 1'b1;
    else                        dir_o[DIR_L] = 1'b1;
  end
endmodule

// File: rtl/xy_chan_fsm.sv
module xy_chan_fsm
  import xy_chan_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     in_req_i,
  input  logic     fifo_full_i,
  input  logic     fifo_empty_i,
  input  logic     out_gnt_i,
  input  dir_vec_t route_dir_i,
  output logic     in_ack_o,
  output logic     wr_en_o,
  output logic     rd_en_o,
  output dir_vec_t out_req_o,
  output logic     out_valid_o
);
  ch_state_e state_q, state_d;
  dir_vec_t  dir_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (in_req_i && !fifo_full_i) state_d = ST_RECV;
      ST_RECV:  if (!in_req_i) state_d = fifo_empty_i ? ST_IDLE : ST_ROUTE;
      ST_ROUTE: state_d = ST_REQ;
      ST_REQ:   if (out_gnt_i) state_d = ST_FWD;
      ST_FWD:   if (fifo_empty_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dir_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_ROUTE) dir_q <= route_dir_i;
    end
  end

  assign in_ack_o    = (state_q == ST_RECV) && !fifo_full_i;
  assign wr_en_o     = in_req_i && in_ack_o;
  assign rd_en_o     = (state_q == ST_FWD);
  assign out_valid_o = (state_q == ST_FWD) && !fifo_empty_i;
  assign out_req_o   = (state_q == ST_REQ) ? dir_q : '0;
endmodule

// File: rtl/xy_input_channel.sv
module xy_input_channel
  import xy_chan_pkg::*;
#(
  parameter int COORD_W = 4,
  parameter int DEPTH   = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [COORD_W-1:0]     local_x_i,
  input  logic [COORD_W-1:0]     local_y_i,
  input  logic                   in_req_i,
  input  logic [2*COORD_W-1:0]   in_data_i,
  output logic                   in_ack_o,
  output logic [NUM_DIRS-1:0]    out_req_o,
  input  logic                   out_gnt_i,
  output logic [2*COORD_W-1:0]   out_data_o,
  output logic                   out_valid_o,
  output logic                   empty_o
);
  localparam int DATA_W = 2 * COORD_W;

  logic              fifo_wr, fifo_rd, fifo_full, fifo_empty;
  logic [DATA_W-1:0] head;
  dir_vec_t          route_dir;

  xy_chan_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (fifo_wr),
    .wr_data_i (in_data_i),
    .rd_en_i   (fifo_rd),
    .rd_data_o (head),
    .full_o    (fifo_full),
    .empty_o   (fifo_empty)
  );

  xy_chan_route #(.COORD_W(COORD_W)) u_route (
    .header_i  (head),
    .local_x_i (local_x_i),
    .local_y_i (local_y_i),
    .dir_o     (route_dir)
  );

  xy_chan_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_req_i     (in_req_i),
    .fifo_full_i  (fifo_full),
    .fifo_empty_i (fifo_empty),
    .out_gnt_i    (out_gnt_i),
    .route_dir_i  (route_dir),
    .in_ack_o     (in_ack_o),
    .wr_en_o      (fifo_wr),
    .rd_en_o      (fifo_rd),
    .out_req_o    (out_req_o),
    .out_valid_o  (out_valid_o)
  );

  assign out_data_o = head;
  assign empty_o    = fifo_empty;
endmodule

// File: rtl/xy_input_channel_chk.sv
module xy_input_channel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_req_i,
  input logic       in_ack_o,
  input logic       out_gnt_i,
  input logic [4:0] out_req_o,
  input logic       out_valid_o,
  input logic       empty_o,
  input logic       fifo_full
);
  a_r2_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ack_o) |-> $past(in_req_i));

  a_r2_no_ack_while_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ack_o);

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_req_i && in_ack_o) |=> !empty_o);

  a_r5_ack_falls_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ack_o) |-> (!$past(in_req_i) || fifo_full));

  a_r8_req_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_req_o));

  a_r8_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_o != 5'd0 && !out_gnt_i) |=> out_req_o == $past(out_req_o));

  a_r8_no_req_during_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_req_o == 5'd0);
endmodule

bind xy_input_channel xy_input_channel_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_req_i    (in_req_i),
  .in_ack_o    (in_ack_o),
  .out_gnt_i   (out_gnt_i),
  .out_req_o   (out_req_o),
  .out_valid_o (out_valid_o),
  .empty_o     (empty_o),
  .fifo_full   (fifo_full)
);

// File: tb/xy_input_channel_bench.sv
`timescale 1ns/1ps
module xy_input_channel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] lx = '0, ly = '0;
  logic       in_req = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ack;
  logic [4:0] out_req;
  logic       out_gnt = 1'b0;
  logic [7:0] out_data;
  logic       out_valid;
  logic       empty;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  logic [7:0] pkt [16];

  always #2.5 clk = ~clk;

  xy_input_channel u_xy_input_channel (
    .clk_i(clk), .rst_ni(rst_n), .local_x_i(lx), .local_y_i(ly),
    .in_req_i(in_req), .in_data_i(in_data), .in_ack_o(in_ack),
    .out_req_o(out_req), .out_gnt_i(out_gnt), .out_data_o(out_data),
    .out_valid_o(out_valid), .empty_o(empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6 R7: bit0 N, bit1 E, bit2 S, bit3 W, bit4 L
  function automatic logic [4:0] exp_dir(input logic [7:0] h, input logic [3:0] x, input logic [3:0] y);
    if (h[7:4] > x) return 5'b00010;
    if (h[7:4] < x) return 5'b01000;
    if (h[3:0] > y) return 5'b00001;
    if (h[3:0] < y) return 5'b00100;
    return 5'b10000;
  endfunction

  task automatic run_pkt(input int n, input int hold);
    int i = 0;
    int guard = 0;
    int got = 0;
    logic [4:0] want;
    want = exp_dir(pkt[0], lx, ly);
    while (i < n && guard < 100) begin
      @(negedge clk);
      in_req  = 1'b1;
      in_data = pkt[i];
      if (in_ack) i++;
      guard++;
    end
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      in_data = 8'hEE;
      chk(!in_ack, "R4 ack while full", in_ack, 0);
    end
    @(negedge clk);
    in_req = 1'b0;
    if (n < 16) chk(in_ack == 1'b1, "R5 ack after req drop", in_ack, 1);
    else        chk(in_ack == 1'b0, "R4 ack low when full", in_ack, 0);
    @(negedge clk);
    chk(!in_ack, "R5 ack fallen", in_ack, 0);
    chk(out_req == 5'd0, "R8 req not yet", out_req, 0);
    @(negedge clk);
    chk(out_req == want, "R6 R7 route", out_req, want);
    for (int k = 0; k < 2; k++) begin
      in_req  = 1'b1;              // R2 busy neighbour
      in_data = 8'h5A;
      @(negedge clk);
      chk(out_req == want, "R8 req held", out_req, want);
      chk(!in_ack, "R2 no ack while busy", in_ack, 0);
    end
    in_req  = 1'b0;
    out_gnt = 1'b1;
    for (int k = 0; k < n + 3; k++) begin
      @(negedge clk);
      if (k == 0) begin
        out_gnt = 1'b0;
        chk(out_req == 5'd0, "R8 req cleared", out_req, 0);
      end
      if (!out_valid) break;
      if (got < 16) chk(out_data == pkt[got], "R9 R3 data", out_data, pkt[got]);
      got++;
    end
    chk(got == n, "R9 R4 flit count", got, n);
    chk(empty == 1'b1, "R10 empty at end", empty, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!in_ack && out_req == 0 && !out_valid && empty, "R1 in reset", {in_ack, out_req, out_valid, empty}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ack && out_req == 0 && !out_valid && empty, "R1 after reset", {in_ack, out_req, out_valid, empty}, 1);

    // destination sweep, local fixed
    lx = 4'd7; ly = 4'd9;
    for (int d = 0; d < 256; d++) begin
      pkt[0] = d[7:0];
      for (int j = 1; j < 16; j++) pkt[j] = 8'((d * 37 + j * 11) & 8'hff);
      run_pkt(1 + (d % 4), 0);
    end
    // local sweep, destination fixed (R10: back-to-back acceptance)
    for (int l = 0; l < 256; l++) begin
      lx = l[7:4]; ly = l[3:0];
      pkt[0] = 8'h5A;
      pkt[1] = 8'(l);
      run_pkt(2, 0);
    end
    // corner coordinates
    lx = 4'd0; ly = 4'd15; pkt[0] = 8'hF0; run_pkt(1, 0);
    lx = 4'd15; ly = 4'd0; pkt[0] = 8'h0F; run_pkt(1, 0);
    // full buffer, with and without extra held request
    lx = 4'd3; ly = 4'd3;
    for (int j = 0; j < 16; j++) pkt[j] = 8'(8'h33 + j * 5);
    run_pkt(16, 4);
    run_pkt(16, 0);
    run_pkt(15, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule